// File: doc/BRIEF.md
# Shared-Buffer Cell Switch with Logical Output Queues

This block is an N x N switch for fixed-length cells. Time is divided into cell times of a fixed number of data words. Each arriving cell is written once into a shared cell memory. Only its slot pointer is placed into logical output queues, one queue for each pair of output and priority. A multicast cell occupies a single slot. Its pointer is copied into every destination queue, and a per-slot reference count returns the slot to the free pool once the last copy has left.

Flow control works by grant instead of by dropping cells. Each logical queue has a programmable occupancy threshold, and its grant bit stays high only while the queue holds fewer pointers than that threshold. Upstream senders only launch a cell when every destination queue it targets is granted. If a cell arrives while no slot is free, the cell is not stored and an error strobe is raised. A correct grant setup never causes this.

Cells are handled in store-and-forward fashion. A cell accepted in cell time T can leave no earlier than cell time T+1. Each output serves its highest-priority nonempty queue first. The slot count must be a power of two, and a cell has at least two words.

Top module: `swSharedSwitch`

## Requirements
- R1: A cell with a nonzero destination bitmap (bit o selects output o) accepted in cell time T to an idle output with an empty queue leaves in cell time T+1. Its word k appears on the k-th cycle of that cell time, and outValid is high for exactly those cycles.
- R2: A multicast cell appears with identical words on every output whose destination bit is set.
- R3: Priority value 0 is served before 1, 2 and 3. Cells of one priority leave one output in arrival order, and cells that arrive in the same cell time are ordered by ascending input index.
- R4: grant bit o*4+p is high exactly when the queue for output o and priority p holds fewer waiting cells than its threshold. A cell being transmitted no longer counts as waiting.
- R5: All thresholds reset to the slot count. A write with cfgWe high sets the threshold of queue (cfgPort, cfgPrio) from the next cycle onward.
- R6: When no slot is free, an arriving cell is discarded and dropErr for its port is high in the first cycle of that cell time. dropErr is never high otherwise.
- R7: A cell with an all-zero destination bitmap is ignored: it raises no dropErr, consumes no slot and appears on no output.
- R8: Cells arriving on all ports in the same cell time are all accepted while enough slots are free. When slots run short, the lower-numbered ports are served first.
- R9: After reset no output is valid and all grants are high.
- R10: cellStart is high in the first cycle of every cell time and low in the others. inValid is sampled only in that first cycle.
- R11: A slot is reused only after every destination copy has been transmitted, so that all slots can be refilled after a full drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cellStart | output | 1 | First cycle of a cell time |
| inValid | input | N | Per-port cell arrival, sampled with cellStart |
| inDest | input | N*N | Per-port destination bitmap, port p in bits p*N +: N |
| inPrio | input | N*PRIO_W | Per-port priority, 0 highest |
| inData | input | N*DATA_W | Per-port cell word for the current cycle |
| dropErr | output | N | Per-port arrival discarded for lack of a slot |
| outValid | output | N | Per-output cell word valid |
| outData | output | N*DATA_W | Per-output cell word |
| grant | output | N*PRIO | Queue grant, index output*PRIO+priority |
| cfgWe | input | 1 | Threshold write strobe |
| cfgPort | input | PORT_W | Output index for the threshold write |
| cfgPrio | input | PRIO_W | Priority index for the threshold write |
| cfgThr | input | CNT_W | Threshold value |

## Verification
A single unicast cell and a multicast cell to three outputs show that one slot is written and read back correctly along one path and along several paths. Contending cells of mixed priority toward one output, some of them in the same cell time, separate the order given by priority from the order given by arrival and port index. A lowered threshold makes a grant fall and rise with queue occupancy. Sustained full-rate traffic to one output exhausts the slots, which reveals which ports are served when slots run short and whether slots are reused after a drain. Zero-bitmap cells and arrivals outside the first cycle show that inputs are ignored where they should be. A long grant-respecting random phase with occasional threshold changes then mixes all of these cases.

// File: rtl/swPkg.sv
package swPkg;
  localparam int MAX_SLOT_BITS = 8;

  // per-port strobes from control to datapath
  typedef struct packed {
    logic                     wrEn;
    logic [MAX_SLOT_BITS-1:0] wrSlot;
    logic                     rdEn;
    logic [MAX_SLOT_BITS-1:0] rdSlot;
  } portStrobe_t;
endpackage

// File: rtl/swCellStore.sv
module swCellStore import swPkg::*; #(
  parameter int N      = 4,
  parameter int SLOTS  = 32,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int PH_W   = 2
) (
  input  logic                   clk,
  input  logic [PH_W-1:0]        wordIdx,
  input  portStrobe_t [N-1:0]    strobes,
  input  logic [N*DATA_W-1:0]    inData,
  output logic [N*DATA_W-1:0]    outData
);
  localparam int DEPTH = SLOTS * WORDS;
  localparam int AW    = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrAddr [N];
  logic [AW-1:0]     rdAddr [N];

  always_comb begin
    for (int p = 0; p < N; p++) begin
      wrAddr[p] = AW'(int'(strobes[p].wrSlot) * WORDS + int'(wordIdx));
      rdAddr[p] = AW'(int'(strobes[p].rdSlot) * WORDS + int'(wordIdx));
    end
  end

  // each cell word is written exactly once into its slot
  always_ff @(posedge clk) begin
    for (int p = 0; p < N; p++) begin
      if (strobes[p].wrEn) mem[wrAddr[p]] <= inData[p*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    for (int o = 0; o < N; o++) begin
      outData[o*DATA_W +: DATA_W] = strobes[o].rdEn ? mem[rdAddr[o]] : '0;
    end
  end
endmodule

// File: rtl/swQueueCtrl.sv
module swQueueCtrl import swPkg::*; #(
  parameter int N      = 4,
  parameter int SLOTS  = 32,
  parameter int PRIO   = 4,
  parameter int WORDS  = 4,
  parameter int PH_W   = 2,
  parameter int SLOT_W = 5,
  parameter int CNT_W  = 6,
  parameter int PRIO_W = 2,
  parameter int PORT_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [N-1:0]          inValid,
  input  logic [N*N-1:0]        inDest,
  input  logic [N*PRIO_W-1:0]   inPrio,
  input  logic                  cfgWe,
  input  logic [PORT_W-1:0]     cfgPort,
  input  logic [PRIO_W-1:0]     cfgPrio,
  input  logic [CNT_W-1:0]      cfgThr,
  output logic [PH_W-1:0]       phase,
  output logic                  cellStart,
  output logic [N-1:0]          dropErr,
  output logic [N-1:0]          outValid,
  output logic [N*PRIO-1:0]     grant,
  output portStrobe_t [N-1:0]   strobes
);
  localparam int NQ    = N * PRIO;
  localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1;
  localparam int REF_W = $clog2(N + 1);

  logic              firstPh, lastPh;
  logic [SLOTS-1:0]  freeMap;
  logic [REF_W-1:0]  refCnt [SLOTS];
  logic [SLOT_W-1:0] curSlot [N];
  logic [N-1:0]      curActive;
  logic [N-1:0]      txActive;
  logic [SLOT_W-1:0] txSlot [N];
  logic [SLOT_W-1:0] qMem [NQ][SLOTS];
  logic [SLOT_W-1:0] qHead [NQ];
  logic [SLOT_W-1:0] qTail [NQ];
  logic [CNT_W-1:0]  qCnt [NQ];
  logic [CNT_W-1:0]  thr [NQ];

  logic [N-1:0]      need, allocOk;
  logic [SLOT_W-1:0] allocSlot [N];
  logic [SLOTS-1:0]  allocMask, availTmp, freedMask;
  logic              foundTmp;
  logic [N-1:0]      pushEn [NQ];
  logic [SLOT_W-1:0] pushOff [NQ][N];
  logic [CNT_W-1:0]  pushCnt [NQ];
  int                pushAcc;
  logic [N-1:0]      selOk;
  logic [QW-1:0]     selQ [N];
  logic [NQ-1:0]     popEn;
  logic [REF_W-1:0]  decCnt [SLOTS];

  assign firstPh   = (phase == '0);
  assign lastPh    = (phase == PH_W'(WORDS - 1));
  assign cellStart = firstPh;
  assign outValid  = txActive;

  // arrivals requesting a slot in this cell time
  always_comb begin
    for (int p = 0; p < N; p++) begin
      need[p] = firstPh && inValid[p] && (inDest[p*N +: N] != '0);
    end
  end

  // slot allocation: chained lowest-free search, ascending port order (R8)
  always_comb begin
    availTmp  = freeMap;
    allocMask = '0;
    allocOk   = '0;
    for (int p = 0; p < N; p++) begin
      allocSlot[p] = '0;
      foundTmp     = 1'b0;
      if (need[p]) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (!foundTmp && availTmp[s]) begin
            foundTmp     = 1'b1;
            allocSlot[p] = SLOT_W'(s);
            availTmp[s]  = 1'b0;
            allocMask[s] = 1'b1;
          end
        end
      end
      allocOk[p] = foundTmp;
    end
  end

  assign dropErr = need & ~allocOk;

  // pointer replication into logical queues, offsets by port order
  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      pushAcc = 0;
      for (int p = 0; p < N; p++) begin
        pushEn[q][p] = allocOk[p] && inDest[p*N + q/PRIO] &&
                       (inPrio[p*PRIO_W +: PRIO_W] == PRIO_W'(q % PRIO));
        pushOff[q][p] = SLOT_W'(pushAcc);
        if (pushEn[q][p]) pushAcc = pushAcc + 1;
      end
      pushCnt[q] = CNT_W'(pushAcc);
    end
  end

  // strict priority selection per output, priority 0 wins
  always_comb begin
    for (int o = 0; o < N; o++) begin
      selOk[o] = 1'b0;
      selQ[o]  = '0;
      for (int pr = PRIO - 1; pr >= 0; pr--) begin
        if (qCnt[o*PRIO + pr] != '0) begin
          selOk[o] = 1'b1;
          selQ[o]  = QW'(o*PRIO + pr);
        end
      end
    end
    popEn = '0;
    for (int q = 0; q < NQ; q++) begin
      for (int o = 0; o < N; o++) begin
        if (lastPh && selOk[o] && selQ[o] == QW'(q)) popEn[q] = 1'b1;
      end
    end
  end

  // departures completing in this cycle, per slot
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      decCnt[s] = '0;
      for (int o = 0; o < N; o++) begin
        if (lastPh && txActive[o] && txSlot[o] == SLOT_W'(s)) decCnt[s] = decCnt[s] + REF_W'(1);
      end
      freedMask[s] = (decCnt[s] != '0) && (refCnt[s] == decCnt[s]);
    end
  end

  always_comb begin
    for (int q = 0; q < NQ; q++) grant[q] = (qCnt[q] < thr[q]);
  end

  always_comb begin
    for (int p = 0; p < N; p++) begin
      strobes[p].wrEn   = firstPh ? allocOk[p] : curActive[p];
      strobes[p].wrSlot = MAX_SLOT_BITS'(firstPh ? allocSlot[p] : curSlot[p]);
      strobes[p].rdEn   = txActive[p];
      strobes[p].rdSlot = MAX_SLOT_BITS'(txSlot[p]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= '0;
      freeMap   <= '1;
      curActive <= '0;
      txActive  <= '0;
      for (int s = 0; s < SLOTS; s++) refCnt[s] <= '0;
      for (int p = 0; p < N; p++) begin
        curSlot[p] <= '0;
        txSlot[p]  <= '0;
      end
      for (int q = 0; q < NQ; q++) begin
        qHead[q] <= '0;
        qTail[q] <= '0;
        qCnt[q]  <= '0;
        thr[q]   <= CNT_W'(SLOTS);
      end
    end else begin
      phase   <= lastPh ? '0 : phase + PH_W'(1);
      freeMap <= (freeMap & ~allocMask) | freedMask;

      for (int s = 0; s < SLOTS; s++) begin
        if (decCnt[s] != '0) refCnt[s] <= refCnt[s] - decCnt[s];
      end
      for (int p = 0; p < N; p++) begin
        if (allocOk[p]) refCnt[allocSlot[p]] <= REF_W'($countones(inDest[p*N +: N]));
      end

      if (firstPh) begin
        curActive <= allocOk;
        for (int p = 0; p < N; p++) curSlot[p] <= allocSlot[p];
      end else if (lastPh) begin
        curActive <= '0;
      end

      if (lastPh) begin
        txActive <= selOk;
        for (int o = 0; o < N; o++) txSlot[o] <= qMem[selQ[o]][qHead[selQ[o]]];
      end

      for (int q = 0; q < NQ; q++) begin
        for (int p = 0; p < N; p++) begin
          if (pushEn[q][p]) qMem[q][qTail[q] + pushOff[q][p]] <= allocSlot[p];
        end
        qTail[q] <= qTail[q] + SLOT_W'(pushCnt[q]);
        if (popEn[q]) qHead[q] <= qHead[q] + SLOT_W'(1);
        qCnt[q] <= qCnt[q] + pushCnt[q] - CNT_W'(popEn[q]);
      end

      if (cfgWe) thr[QW'(int'(cfgPort) * PRIO + int'(cfgPrio))] <= cfgThr;
    end
  end
endmodule

// File: rtl/swSharedSwitch.sv
module swSharedSwitch import swPkg::*; #(
  parameter int N      = 4,
  parameter int SLOTS  = 32,
  parameter int PRIO   = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int PORT_W = (N > 1) ? $clog2(N) : 1,
  localparam int PRIO_W = (PRIO > 1) ? $clog2(PRIO) : 1,
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int PH_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  output logic                  cellStart,
  input  logic [N-1:0]          inValid,
  input  logic [N*N-1:0]        inDest,
  input  logic [N*PRIO_W-1:0]   inPrio,
  input  logic [N*DATA_W-1:0]   inData,
  output logic [N-1:0]          dropErr,
  output logic [N-1:0]          outValid,
  output logic [N*DATA_W-1:0]   outData,
  output logic [N*PRIO-1:0]     grant,
  input  logic                  cfgWe,
  input  logic [PORT_W-1:0]     cfgPort,
  input  logic [PRIO_W-1:0]     cfgPrio,
  input  logic [CNT_W-1:0]      cfgThr
);
  logic [PH_W-1:0]     phase;
  portStrobe_t [N-1:0] strobes;

  swQueueCtrl #(
    .N(N), .SLOTS(SLOTS), .PRIO(PRIO), .WORDS(WORDS), .PH_W(PH_W),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W), .PRIO_W(PRIO_W), .PORT_W(PORT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest), .inPrio(inPrio),
    .cfgWe(cfgWe), .cfgPort(cfgPort), .cfgPrio(cfgPrio), .cfgThr(cfgThr),
    .phase(phase), .cellStart(cellStart), .dropErr(dropErr), .outValid(outValid),
    .grant(grant), .strobes(strobes)
  );

  swCellStore #(
    .N(N), .SLOTS(SLOTS), .WORDS(WORDS), .DATA_W(DATA_W), .PH_W(PH_W)
  ) uStore (
    .clk(clk), .wordIdx(phase), .strobes(strobes), .inData(inData), .outData(outData)
  );
endmodule

// File: rtl/swSwitchChecker.sv
module swSwitchChecker #(
  parameter int N  = 4,
  parameter int NQ = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          cellStart,
  input logic [N-1:0]  inValid,
  input logic [N*N-1:0] inDest,
  input logic [N-1:0]  dropErr,
  input logic [N-1:0]  outValid,
  input logic [NQ-1:0] grant,
  input logic          cfgWe
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) cellStart |=> !cellStart); // R10

  for (genvar p = 0; p < N; p++) begin : gPort
    AST_DROP_ONLY_REAL_ARRIVAL: assert property (@(posedge clk) disable iff (!rstN)
      dropErr[p] |-> (cellStart && inValid[p] && (inDest[p*N +: N] != '0))); // R6
    AST_TX_STARTS_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
      $rose(outValid[p]) |-> cellStart); // R1
    AST_TX_HELD_IN_CELL: assert property (@(posedge clk) disable iff (!rstN)
      !cellStart |-> $stable(outValid[p])); // R1
  end

  for (genvar q = 0; q < NQ; q++) begin : gQueue
    AST_GRANT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(grant[q]) |-> ($past(cellStart) || $past(cfgWe))); // R4
  end
endmodule

bind swSharedSwitch swSwitchChecker #(.N(N), .NQ(N*PRIO)) uChk (
  .clk(clk), .rstN(rstN), .cellStart(cellStart), .inValid(inValid), .inDest(inDest),
  .dropErr(dropErr), .outValid(outValid), .grant(grant), .cfgWe(cfgWe)
);

// File: tb/tb_swSharedSwitch.sv
`timescale 1ns/1ps
module tb_swSharedSwitch;
  localparam int N = 4, SLOTS = 32, PRIO = 4, WORDS = 4, DATA_W = 32;
  localparam int NQ = N * PRIO, MQ = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cellStart;
  logic [N-1:0] inValid, dropErr, outValid;
  logic [N*N-1:0] inDest;
  logic [N*2-1:0] inPrio;
  logic [N*DATA_W-1:0] inData, outData;
  logic [NQ-1:0] grant;
  logic cfgWe;
  logic [1:0] cfgPort, cfgPrio;
  logic [5:0] cfgThr;

  always #2 clk = ~clk;

  swSharedSwitch #(.N(N), .SLOTS(SLOTS), .PRIO(PRIO), .WORDS(WORDS), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .cellStart(cellStart), .inValid(inValid), .inDest(inDest),
    .inPrio(inPrio), .inData(inData), .dropErr(dropErr), .outValid(outValid),
    .outData(outData), .grant(grant), .cfgWe(cfgWe), .cfgPort(cfgPort),
    .cfgPrio(cfgPrio), .cfgThr(cfgThr)
  );

  int checks = 0, errors = 0;
  // reference model
  int mq [NQ][MQ];
  int mh [NQ];
  int mc [NQ];
  int mThr [NQ];
  int tagRef [4096];
  int freeCnt;
  bit expTx [N];
  int expTag [N];
  int nextTag = 1;
  // stimulus for the next cell time
  bit sV [N];
  logic [N-1:0] sD [N];
  int sP [N];
  int sTag [N];
  bit junkValid = 0;
  bit cfgPend = 0;
  int cfgO, cfgPr, cfgV;
  string curReq = "R1";

  function automatic logic [DATA_W-1:0] wordOf(int tag, int k);
    return {tag[23:0], k[7:0]};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic stage(int p, logic [N-1:0] d, int pr);
    sV[p] = 1; sD[p] = d; sP[p] = pr;
  endtask

  task automatic checkOutputs(int k);
    for (int o = 0; o < N; o++) begin
      check(outValid[o] == expTx[o], curReq, $sformatf("outValid[%0d] word %0d", o, k),
            64'(outValid[o]), 64'(expTx[o]));
      if (expTx[o])
        check(outData[o*DATA_W +: DATA_W] == wordOf(expTag[o], k), curReq,
              $sformatf("outData[%0d] word %0d", o, k),
              64'(outData[o*DATA_W +: DATA_W]), 64'(wordOf(expTag[o], k)));
    end
  endtask

  task automatic modelEnd();
    for (int o = 0; o < N; o++) begin
      if (expTx[o]) begin
        tagRef[expTag[o]]--;
        if (tagRef[expTag[o]] == 0) freeCnt++;
      end
    end
    for (int o = 0; o < N; o++) begin
      expTx[o] = 0;
      for (int pr = 0; pr < PRIO; pr++) begin
        int q;
        q = o*PRIO + pr;
        if (!expTx[o] && mc[q] > 0) begin
          expTx[o] = 1;
          expTag[o] = mq[q][mh[q]];
          mh[q] = (mh[q] + 1) % MQ;
          mc[q]--;
        end
      end
    end
  endtask

  // one full cell time, entered and left at a negedge in the first cycle
  task automatic runCell();
    logic [N-1:0] expDrop;
    logic [NQ-1:0] expGrant;
    check(cellStart == 1'b1, "R10", "cellStart in first cycle", 64'(cellStart), 64'd1);
    for (int q = 0; q < NQ; q++) expGrant[q] = (mc[q] < mThr[q]);
    check(grant == expGrant, "R4/R5", "grant vector", 64'(grant), 64'(expGrant));
    expDrop = '0;
    for (int p = 0; p < N; p++) begin
      sTag[p] = 0;
      if (sV[p] && sD[p] != '0) begin
        sTag[p] = nextTag;
        nextTag++;
        if (freeCnt > 0) begin
          freeCnt--;
          tagRef[sTag[p]] = $countones(sD[p]);
          for (int o = 0; o < N; o++) begin
            if (sD[p][o]) begin
              int q;
              q = o*PRIO + sP[p];
              mq[q][(mh[q] + mc[q]) % MQ] = sTag[p];
              mc[q]++;
            end
          end
        end else expDrop[p] = 1'b1;
      end
      inValid[p] = sV[p];
      inDest[p*N +: N] = sD[p];
      inPrio[p*2 +: 2] = 2'(sP[p]);
      inData[p*DATA_W +: DATA_W] = wordOf(sTag[p], 0);
    end
    if (cfgPend) begin
      cfgWe = 1'b1; cfgPort = 2'(cfgO); cfgPrio = 2'(cfgPr); cfgThr = 6'(cfgV);
    end
    #1;
    check(dropErr == expDrop, "R6", "dropErr at cell start", 64'(dropErr), 64'(expDrop));
    checkOutputs(0);
    if (cfgPend) begin
      mThr[cfgO*PRIO + cfgPr] = cfgV;
      cfgPend = 0;
    end
    for (int k = 1; k < WORDS; k++) begin
      @(negedge clk);
      cfgWe = 1'b0;
      for (int p = 0; p < N; p++) begin
        inValid[p] = junkValid;
        inDest[p*N +: N] = junkValid ? 4'b1111 : sD[p];
        inData[p*DATA_W +: DATA_W] = wordOf(sTag[p], k);
      end
      #1;
      check(dropErr == '0, "R10", "dropErr outside first cycle", 64'(dropErr), 64'd0);
      checkOutputs(k);
    end
    @(negedge clk);
    modelEnd();
    for (int p = 0; p < N; p++) begin
      sV[p] = 0; sD[p] = '0; sP[p] = 0;
    end
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'h5EED));
    inValid = '0; inDest = '0; inPrio = '0; inData = '0;
    cfgWe = 0; cfgPort = '0; cfgPrio = '0; cfgThr = '0;
    freeCnt = SLOTS;
    for (int q = 0; q < NQ; q++) begin mh[q] = 0; mc[q] = 0; mThr[q] = SLOTS; end
    for (int o = 0; o < N; o++) begin expTx[o] = 0; expTag[o] = 0; end
    for (int p = 0; p < N; p++) begin sV[p] = 0; sD[p] = '0; sP[p] = 0; sTag[p] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outValid == '0, "R9", "outValid after reset", 64'(outValid), 64'd0);
    check(grant == '1, "R9", "grants after reset (R5 thresholds)", 64'(grant), 64'hFFFF);
    @(negedge clk);
    // the first runCell starts here; wait for alignment to the next cell start
    while (cellStart !== 1'b1) @(negedge clk);

    curReq = "R1";  // unicast input 0 -> output 2
    stage(0, 4'b0100, 1);
    repeat (3) runCell();

    curReq = "R2";  // multicast input 1 -> outputs 0,1,3
    stage(1, 4'b1011, 2);
    repeat (3) runCell();

    curReq = "R3";  // priority and same-cell-time ordering on output 0
    stage(0, 4'b0001, 3); stage(1, 4'b0001, 0); stage(2, 4'b0001, 0); stage(3, 4'b0001, 1);
    runCell();
    stage(3, 4'b0001, 0);
    repeat (6) runCell();

    curReq = "R5";  // threshold write for output 3 priority 2
    cfgPend = 1; cfgO = 3; cfgPr = 2; cfgV = 1;
    runCell();
    curReq = "R4";
    stage(0, 4'b1000, 2); stage(1, 4'b1000, 2); stage(2, 4'b1000, 2);
    repeat (6) runCell();
    cfgPend = 1; cfgO = 3; cfgPr = 2; cfgV = SLOTS;
    runCell();

    curReq = "R7";  // zero bitmap and arrivals outside the first cycle
    stage(0, 4'b0000, 0); stage(2, 4'b0000, 3);
    junkValid = 1;
    repeat (3) runCell();
    junkValid = 0;

    curReq = "R8";  // exhaust slots from all ports toward output 0
    for (int t = 0; t < 12; t++) begin
      for (int p = 0; p < N; p++) stage(p, 4'b0001, 3);
      runCell();
    end
    curReq = "R11";
    repeat (36) runCell();
    for (int p = 0; p < N; p++) stage(p, 4'b1111, 0);
    repeat (6) runCell();

    curReq = "R3";  // random grant-respecting traffic
    for (int t = 0; t < 220; t++) begin
      for (int p = 0; p < N; p++) begin
        if ($urandom_range(1, 0) == 1) begin
          int pr;
          bit ok;
          d = 4'($urandom_range(15, 1));
          pr = $urandom_range(3, 0);
          ok = 1;
          for (int o = 0; o < N; o++) if (d[o] && mc[o*PRIO + pr] >= mThr[o*PRIO + pr]) ok = 0;
          if (ok) stage(p, d, pr);
        end
      end
      if ($urandom_range(9, 0) == 0) begin
        cfgPend = 1;
        cfgO = $urandom_range(3, 0);
        cfgPr = $urandom_range(3, 0);
        cfgV = $urandom_range(8, 1);
      end
      runCell();
    end
    curReq = "R1";
    repeat (40) runCell();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule